// File: doc/BRIEF.md
# Serial FIFO Watermark Status Unit

This block sits between a host bus and the shifter of a synchronous serial port. It holds a receive queue and a transmit queue. The host pops received words by reading the receive data port and pushes outgoing words by writing the transmit data port. The shifter side pushes words it has received and pops words it is about to send. Serial shifting, frame sync and bit clocking live elsewhere.

Each queue has a programmable threshold. The receive flag reports that at least the threshold number of words are waiting to be read. The transmit flag reports that the queue holds fewer words than its threshold, so the host may refill it. Each flag becomes an interrupt request only when its interrupt enable and its queue enable are both set. A module enable bit flushes both queues and forces the flags to their idle values. Clearing that bit leaves the 16-bit control word unchanged.

Top module: `sfifo_wm_status`

## Requirements
- R1: After reset the control word reads 0x0000, both levels read 0, the receive flag is 0, the transmit flag is 1, and both interrupt requests and the overflow flag are 0.
- R2: The control word holds the following fields. Bit 0 is the module enable. Bit 1 is the receive queue enable and bit 2 the transmit queue enable. Bit 3 is the receive interrupt enable and bit 4 the transmit interrupt enable. Bits 11:8 hold the receive threshold and bits 15:12 the transmit threshold. A threshold of 0 acts as 1 and any value above the depth (8) acts as 8. With the module and the receive queue enabled, the receive flag is 1 exactly when the receive level is at or above the threshold.
- R3: A host read that takes the receive level below the threshold clears the receive flag.
- R4: A shifter push into a full receive queue (8 words) is discarded. This holds even when a host read happens in the same cycle. The level stays at 8 and the stored words keep their order.
- R5: A host read of a non-empty receive queue returns the oldest word on the data port one cycle later. A read of an empty queue leaves the data port holding the last word read.
- R6: With the module and the transmit queue enabled, the transmit flag is 1 exactly when the transmit level is below the transmit threshold. It clears once host writes bring the level up to the threshold.
- R7: A host write to a full transmit queue is ignored and sets a sticky overflow flag. Only reset or a cleared module enable clears that flag.
- R8: The receive interrupt is 1 only when the receive flag, the receive interrupt enable and the receive queue enable are all 1. The transmit interrupt follows the same rule with the transmit flag and the transmit enables.
- R9: While the module enable is 0, the receive flag is 0 and the transmit flag is 1. Both queues empty within two cycles and pushes and writes are ignored. The control word keeps the value last written.
- R10: With a queue's enable at 0, its flag uses a threshold of 1, whatever the threshold field holds. The receive flag then means at least one word is stored, and the transmit flag means the queue is empty.
- R11: The shifter transmit port shows the oldest stored word and raises its valid output while the transmit queue holds data. A pop removes that word and words leave in write order. A pop of an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Current control word |
| rx_rd | input | 1 | Host read strobe for the receive queue |
| rx_rdata | output | DATA_W | Last word popped by the host |
| tx_wr | input | 1 | Host write strobe for the transmit queue |
| tx_wdata | input | DATA_W | Host transmit word |
| sh_rx_push | input | 1 | Shifter push of a received word |
| sh_rx_data | input | DATA_W | Received word from the shifter |
| sh_tx_pop | input | 1 | Shifter pop of the oldest transmit word |
| sh_tx_data | output | DATA_W | Oldest transmit word |
| sh_tx_valid | output | 1 | Transmit queue holds data |
| rx_level | output | CNT_W | Receive fill level |
| tx_level | output | CNT_W | Transmit fill level |
| rx_flag | output | 1 | Receive threshold flag |
| tx_flag | output | 1 | Transmit threshold flag |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_ovf | output | 1 | Sticky transmit overflow |

## Verification
The bench builds the block with its defaults: a depth of 8, 16-bit words and 4-bit threshold fields. With a depth of 8, both queues fill in a few writes, so the full-queue drop, the ignored write, the sticky overflow and the ordered drain are all quick to reach. A 4-bit field can hold values above the depth as well as zero, so both clamp corners of the threshold are exercised. It also runs thresholds of 2 and 3 with the queue enables on and off.

// File: rtl/sfws_pkg.sv
package sfws_pkg;

    localparam int CTRL_W = 16;

    // control word, bit 0 is the module enable
    typedef struct packed {
        logic [3:0] tx_wm;
        logic [3:0] rx_wm;
        logic [2:0] spare;
        logic       tx_ie;
        logic       rx_ie;
        logic       tx_fen;
        logic       rx_fen;
        logic       mod_en;
    } ctrl_t;

endpackage

// File: rtl/sfws_fifo.sv
module sfws_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] level
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = ptr_inc(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = ptr_inc(st_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign level = st_q.cnt;

endmodule

// File: rtl/sfws_flag_unit.sv
module sfws_flag_unit #(
    parameter int DEPTH = 8,
    parameter int WM_W  = 4,
    parameter bit IS_RX = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = ((CNT_W > WM_W) ? CNT_W : WM_W) + 1
) (
    input  logic             mod_en,
    input  logic             fifo_en,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] level,
    input  logic [WM_W-1:0]  wm_raw,
    output logic             flag,
    output logic             irq
);

    logic [CMP_W-1:0] thr;
    logic [CMP_W-1:0] lvl;

    always_comb begin
        lvl = CMP_W'(level);
        if (!fifo_en || (wm_raw == '0))
            thr = CMP_W'(1);
        else if (CMP_W'(wm_raw) > CMP_W'(DEPTH))
            thr = CMP_W'(DEPTH);
        else
            thr = CMP_W'(wm_raw);
    end

    generate
        if (IS_RX) begin : g_rx
            assign flag = mod_en && (lvl >= thr);
        end else begin : g_tx
            assign flag = !mod_en || (lvl < thr);
        end
    endgenerate

    assign irq = flag && irq_en && fifo_en;

endmodule

// File: rtl/sfifo_wm_status.sv
module sfifo_wm_status
    import sfws_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int WM_W   = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              sh_rx_push,
    input  logic [DATA_W-1:0] sh_rx_data,
    input  logic              sh_tx_pop,
    output logic [DATA_W-1:0] sh_tx_data,
    output logic              sh_tx_valid,
    output logic [CNT_W-1:0]  rx_level,
    output logic [CNT_W-1:0]  tx_level,
    output logic              rx_flag,
    output logic              tx_flag,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              tx_ovf
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rx_rdata;
        logic              tx_ovf;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              en;
    logic              rx_pop_ok;
    logic              tx_full;
    logic [DATA_W-1:0] rx_head;

    assign en        = st_q.ctrl.mod_en;
    assign rx_pop_ok = en && rx_rd && (rx_level != '0);
    assign tx_full   = (tx_level == CNT_W'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.ctrl = ctrl_t'(ctrl_wdata);
        if (rx_pop_ok) st_d.rx_rdata = rx_head;
        if (!en)
            st_d.tx_ovf = 1'b0;
        else if (tx_wr && tx_full)
            st_d.tx_ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sfws_fifo #(.W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .push  (en && sh_rx_push),
        .din   (sh_rx_data),
        .pop   (en && rx_rd),
        .head  (rx_head),
        .level (rx_level)
    );

    sfws_fifo #(.W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .push  (en && tx_wr),
        .din   (tx_wdata),
        .pop   (en && sh_tx_pop),
        .head  (sh_tx_data),
        .level (tx_level)
    );

    sfws_flag_unit #(.DEPTH(DEPTH), .WM_W(WM_W), .IS_RX(1'b1)) rx_flag_i (
        .mod_en  (en),
        .fifo_en (st_q.ctrl.rx_fen),
        .irq_en  (st_q.ctrl.rx_ie),
        .level   (rx_level),
        .wm_raw  (st_q.ctrl.rx_wm),
        .flag    (rx_flag),
        .irq     (rx_irq)
    );

    sfws_flag_unit #(.DEPTH(DEPTH), .WM_W(WM_W), .IS_RX(1'b0)) tx_flag_i (
        .mod_en  (en),
        .fifo_en (st_q.ctrl.tx_fen),
        .irq_en  (st_q.ctrl.tx_ie),
        .level   (tx_level),
        .wm_raw  (st_q.ctrl.tx_wm),
        .flag    (tx_flag),
        .irq     (tx_irq)
    );

    assign ctrl_rdata  = st_q.ctrl;
    assign rx_rdata    = st_q.rx_rdata;
    assign tx_ovf      = st_q.tx_ovf;
    assign sh_tx_valid = en && (tx_level != '0);

endmodule

// File: rtl/sfws_chk.sv
module sfws_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic             rx_fen,
    input logic             tx_fen,
    input logic             rx_ie,
    input logic             tx_ie,
    input logic             sh_rx_push,
    input logic             rx_rd,
    input logic             tx_wr,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic             rx_flag,
    input logic             tx_flag,
    input logic             rx_irq,
    input logic             tx_irq,
    input logic             tx_ovf
);

    // R8
    rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_flag && rx_ie && rx_fen));

    // R8
    tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_flag && tx_ie && tx_fen));

    // R9
    disable_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> (!rx_flag && tx_flag));

    // R9
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (rx_level == '0 && tx_level == '0));

    // R4
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && rx_level == CNT_W'(DEPTH) && sh_rx_push && !rx_rd)
        |=> (rx_level == CNT_W'(DEPTH)));

    // R7
    tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && tx_level == CNT_W'(DEPTH) && tx_wr) |=> tx_ovf);

    // R7
    tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && tx_ovf) |=> tx_ovf);

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= CNT_W'(DEPTH)) && (tx_level <= CNT_W'(DEPTH)));

endmodule

bind sfifo_wm_status sfws_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_en     (ctrl_rdata[0]),
    .rx_fen     (ctrl_rdata[1]),
    .tx_fen     (ctrl_rdata[2]),
    .rx_ie      (ctrl_rdata[3]),
    .tx_ie      (ctrl_rdata[4]),
    .sh_rx_push (sh_rx_push),
    .rx_rd      (rx_rd),
    .tx_wr      (tx_wr),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_flag    (rx_flag),
    .tx_flag    (tx_flag),
    .rx_irq     (rx_irq),
    .tx_irq     (tx_irq),
    .tx_ovf     (tx_ovf)
);

// File: tb/sfifo_wm_status_tb_top.sv
module sfifo_wm_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_rdata;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        sh_rx_push = 1'b0;
    logic [15:0] sh_rx_data = '0;
    logic        sh_tx_pop = 1'b0;
    logic [15:0] sh_tx_data;
    logic        sh_tx_valid;
    logic [3:0]  rx_level, tx_level;
    logic        rx_flag, tx_flag, rx_irq, tx_irq, tx_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sfifo_wm_status dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .sh_rx_push(sh_rx_push),
        .sh_rx_data(sh_rx_data), .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
        .sh_tx_valid(sh_tx_valid), .rx_level(rx_level), .tx_level(tx_level),
        .rx_flag(rx_flag), .tx_flag(tx_flag), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .tx_ovf(tx_ovf)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ctrl_put(input logic [15:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_push(input logic [15:0] v);
        @(negedge clk); sh_rx_push = 1'b1; sh_rx_data = v;
        @(negedge clk); sh_rx_push = 1'b0;
    endtask

    task automatic rx_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic tx_write(input logic [15:0] v);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic tx_pop();
        @(negedge clk); sh_tx_pop = 1'b1;
        @(negedge clk); sh_tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "ctrl", ctrl_rdata, 32'h0);
        chk("R1", "rx_level", rx_level, 0);
        chk("R1", "tx_level", tx_level, 0);
        chk("R1", "rx_flag", rx_flag, 0);
        chk("R1", "tx_flag", tx_flag, 1);
        chk("R1", "irqs", {rx_irq, tx_irq}, 0);
        chk("R1", "tx_ovf", tx_ovf, 0);
    endtask

    task automatic t_rx_wm();
        ctrl_put(16'h231F);
        rx_push(16'hA000);
        rx_push(16'hA001);
        chk("R2", "rx_flag below wm", rx_flag, 0);
        chk("R8", "rx_irq below wm", rx_irq, 0);
        rx_push(16'hA002);
        chk("R2", "rx_flag at wm", rx_flag, 1);
        chk("R8", "rx_irq at wm", rx_irq, 1);
        rx_read();
        chk("R3", "rx_flag after read", rx_flag, 0);
        chk("R5", "rx_rdata first", rx_rdata, 32'hA000);
    endtask

    task automatic t_rx_full();
        for (int i = 3; i <= 10; i++) rx_push(16'hA000 + 16'(i));
        chk("R4", "rx_level full", rx_level, 8);
        // push with a read in the same cycle while full is dropped
        @(negedge clk); sh_rx_push = 1'b1; sh_rx_data = 16'hBEEF; rx_rd = 1'b1;
        @(negedge clk); sh_rx_push = 1'b0; rx_rd = 1'b0;
        chk("R4", "rx_level after drop+read", rx_level, 7);
        chk("R5", "rx_rdata second", rx_rdata, 32'hA001);
        for (int i = 2; i <= 8; i++) begin
            rx_read();
            chk("R4", "rx order", rx_rdata, 32'hA000 + i);
        end
        chk("R4", "rx_level drained", rx_level, 0);
        rx_read();
        chk("R5", "empty read holds", rx_rdata, 32'hA008);
    endtask

    task automatic t_tx();
        chk("R6", "tx_flag empty", tx_flag, 1);
        chk("R8", "tx_irq empty", tx_irq, 1);
        tx_write(16'hC000);
        chk("R6", "tx_flag level1", tx_flag, 1);
        tx_write(16'hC001);
        chk("R6", "tx_flag at wm", tx_flag, 0);
        chk("R8", "tx_irq at wm", tx_irq, 0);
    endtask

    task automatic t_tx_ovf();
        for (int i = 2; i < 8; i++) tx_write(16'hC000 + 16'(i));
        chk("R7", "ovf before", tx_ovf, 0);
        tx_write(16'hDEAD);
        chk("R7", "ovf set", tx_ovf, 1);
        chk("R7", "tx_level full", tx_level, 8);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R11", "tx valid", sh_tx_valid, 1);
            chk("R11", "tx order", sh_tx_data, 32'hC000 + i);
            tx_pop();
        end
        chk("R11", "tx valid empty", sh_tx_valid, 0);
        tx_pop();
        chk("R11", "pop empty level", tx_level, 0);
        chk("R7", "ovf sticky", tx_ovf, 1);
    endtask

    task automatic t_irq_gate();
        ctrl_put(16'h2307);
        chk("R8", "tx_flag w/o ie", tx_flag, 1);
        chk("R8", "tx_irq w/o ie", tx_irq, 0);
    endtask

    task automatic t_fifo_dis();
        ctrl_put(16'h2319);
        chk("R10", "tx_flag fen off empty", tx_flag, 1);
        chk("R10", "tx_irq fen off", tx_irq, 0);
        rx_push(16'h1111);
        chk("R10", "rx_flag fen off one word", rx_flag, 1);
        chk("R10", "rx_irq fen off", rx_irq, 0);
        tx_write(16'h2222);
        chk("R10", "tx_flag fen off one word", tx_flag, 0);
    endtask

    task automatic t_disable();
        ctrl_put(16'h2318);
        chk("R9", "rx_level flushed", rx_level, 0);
        chk("R9", "tx_level flushed", tx_level, 0);
        chk("R9", "rx_flag off", rx_flag, 0);
        chk("R9", "tx_flag on", tx_flag, 1);
        chk("R7", "ovf cleared by disable", tx_ovf, 0);
        rx_push(16'h3333);
        tx_write(16'h4444);
        chk("R9", "rx push ignored", rx_level, 0);
        chk("R9", "tx write ignored", tx_level, 0);
        chk("R9", "ctrl kept", ctrl_rdata, 32'h2318);
    endtask

    task automatic t_wm_clamp();
        ctrl_put(16'h0003);
        rx_push(16'h5000);
        chk("R2", "wm 0 acts as 1", rx_flag, 1);
        ctrl_put(16'h0F03);
        chk("R2", "wm 15 level 1", rx_flag, 0);
        for (int i = 1; i < 8; i++) rx_push(16'h5000 + 16'(i));
        chk("R2", "wm 15 acts as 8", rx_flag, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_wm();
        t_rx_full();
        t_tx();
        t_tx_ovf();
        t_irq_gate();
        t_fifo_dis();
        t_disable();
        t_wm_clamp();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule